// File: doc/BRIEF.md
# Single-Cycle Control Decoder

This block turns one 32-bit RV32I instruction word, together with the equal and less-than flags from the branch comparator, into the complete set of control signals a single-cycle datapath needs. These signals are the next-PC select, the immediate format, the register-file write enable, the comparator signedness, the two ALU operand selects, the ALU operation, the data-memory write strobe and the write-back source. It contains no state. Every output follows the inputs within the same cycle, so the datapath fetches, decodes, executes and retires an instruction in one clock.

The decoder first sorts the opcode into one of nine instruction classes. Each class selects a fixed row of control values. The ALU operation comes from funct3 and instruction bit 30 where the class calls for it. For conditional branches, the comparator flags and funct3 decide the next-PC select. An opcode outside the nine classes gets a safe row, in which nothing is written and the PC advances by four. Outputs marked don't-care below still carry defined values, but a testbench must not rely on them.

Encodings: ImmSel I=0, S=1, B=2, J=3, U=4. WBSel memory=0, ALU=1, PC+4=2. PCSel 0=PC+4, 1=ALU result. ASel 0=rs1, 1=PC. BSel 0=rs2, 1=immediate. MemRW 0=read, 1=write. ALUSel is {bit30, funct3} for register operations: add=0000, sub=1000, sll=0001, slt=0010, sltu=0011, xor=0100, srl=0101, sra=1101, or=0110, and=0111. Pass-B is 1111. Opcodes: register 0110011, immediate ALU 0010011, load 0000011, store 0100011, branch 1100011, jalr 1100111, jal 1101111, lui 0110111, auipc 0010111.

Top module: `rv_ctrl_decode`

## Requirements
- R1: Register opcode gives RegWEn=1, ASel=0, BSel=0, WBSel=1, PCSel=0, MemRW=0, and ALUSel={inst[30], funct3}.
- R2: Immediate-ALU opcode gives ImmSel=0, RegWEn=1, ASel=0, BSel=1, WBSel=1, PCSel=0, MemRW=0. ALUSel is {inst[30], 101} when funct3=101 and {0, funct3} otherwise, so inst[30] never turns addi or andi into another operation.
- R3: Load opcode gives ImmSel=0, RegWEn=1, ASel=0, BSel=1, ALUSel=0000, MemRW=0, WBSel=0, PCSel=0.
- R4: Store opcode gives ImmSel=1, RegWEn=0, ASel=0, BSel=1, ALUSel=0000, MemRW=1, PCSel=0. MemRW=1 never comes with RegWEn=1.
- R5: Branch opcode gives ImmSel=2, RegWEn=0, ASel=1, BSel=1, ALUSel=0000, MemRW=0. BrUn equals funct3 bit 1, which is 1 for bltu (110) and bgeu (111) and 0 for the signed branches.
- R6: For branches, PCSel=1 exactly when the branch is taken: beq (000) on BrEq, bne (001) on !BrEq, blt/bltu (100/110) on BrLT, bge/bgeu (101/111) on !BrLT. Codes 010 and 011 are never taken.
- R7: jalr gives ImmSel=0, RegWEn=1, ASel=0, BSel=1, ALUSel=0000, MemRW=0, WBSel=2, PCSel=1.
- R8: jal gives ImmSel=3, RegWEn=1, ASel=1, BSel=1, ALUSel=0000, MemRW=0, WBSel=2, PCSel=1.
- R9: lui gives ImmSel=4, RegWEn=1, BSel=1, ALUSel=1111 (pass-B), MemRW=0, WBSel=1, PCSel=0.
- R10: auipc gives ImmSel=4, RegWEn=1, ASel=1, BSel=1, ALUSel=0000, MemRW=0, WBSel=1, PCSel=0.
- R11: Any other opcode gives RegWEn=0, MemRW=0 and PCSel=0, whatever the flags are.
- R12: BrEq and BrLT change no output for any non-branch opcode.
- R13: WBSel never shows 3 and ImmSel never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_i | input | INST_W (32) | Instruction word |
| br_eq_i | input | 1 | Comparator: operands equal |
| br_lt_i | input | 1 | Comparator: rs1 less than rs2 |
| pc_sel_o | output | 1 | Next PC: 0 PC+4, 1 ALU result |
| imm_sel_o | output | IMM_SEL_W (3) | Immediate format select |
| reg_wen_o | output | 1 | Register file write enable |
| br_unsigned_o | output | 1 | Comparator unsigned mode |
| a_sel_o | output | 1 | ALU A: 0 rs1, 1 PC |
| b_sel_o | output | 1 | ALU B: 0 rs2, 1 immediate |
| alu_sel_o | output | ALU_SEL_W (4) | ALU operation |
| mem_write_o | output | 1 | Data memory write strobe |
| wb_sel_o | output | WB_SEL_W (2) | Write-back source |

## Verification
Two things meet in one evaluation: the comparator flags feed next-PC resolution, while the opcode class gates that resolution and every write enable. A flag that leaks past its class would redirect the PC or change an output on a non-branch or illegal instruction. The bench provokes this by holding both flags high while it applies unknown opcodes, an add and the other non-branch classes. It judges the result by checking that PCSel stays 0 for unknown opcodes and that every output matches its flags-low value. It then sweeps all eight branch funct3 codes against all four flag combinations and compares PCSel and BrUn with the taken table.

// File: rtl/rvcd_pkg.sv
package rvcd_pkg;

   // Major opcodes of the supported subset
   localparam logic [6:0] OPC_REG    = 7'b0110011;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;

   // Native widths of the decoded fields
   localparam int unsigned OPC_W    = 7;
   localparam int unsigned F3_W     = 3;
   localparam int unsigned ALU_CODE_W = 4;
   localparam int unsigned IMM_CODE_W = 3;
   localparam int unsigned WB_CODE_W  = 2;

   localparam logic [ALU_CODE_W-1:0] ALU_CODE_ADD   = 4'b0000;
   localparam logic [ALU_CODE_W-1:0] ALU_CODE_PASSB = 4'b1111;
   localparam logic [F3_W-1:0]       F3_SHIFT_RIGHT = 3'b101;

   typedef enum logic [3:0] {
      CL_NONE,
      CL_REG,
      CL_OPIMM,
      CL_LOAD,
      CL_STORE,
      CL_BRANCH,
      CL_JALR,
      CL_JAL,
      CL_LUI,
      CL_AUIPC
   } iclass_e;

   typedef enum logic [IMM_CODE_W-1:0] {
      IMM_I = 3'd0,
      IMM_S = 3'd1,
      IMM_B = 3'd2,
      IMM_J = 3'd3,
      IMM_U = 3'd4
   } imm_kind_e;

   typedef enum logic [WB_CODE_W-1:0] {
      WB_MEM  = 2'd0,
      WB_ALU  = 2'd1,
      WB_LINK = 2'd2
   } wb_src_e;

   typedef enum logic [1:0] {
      AM_ADD,
      AM_REG,
      AM_IMM,
      AM_PASSB
   } alu_mode_e;

   // One row of static control per instruction class
   typedef struct packed {
      logic      jump;
      imm_kind_e imm;
      logic      reg_wen;
      logic      a_pc;
      logic      b_imm;
      logic      mem_wr;
      wb_src_e   wb;
      alu_mode_e alu_mode;
   } ctrl_row_t;

   localparam ctrl_row_t ROW_QUIET = '{
      jump: 1'b0, imm: IMM_I, reg_wen: 1'b0, a_pc: 1'b0, b_imm: 1'b0,
      mem_wr: 1'b0, wb: WB_MEM, alu_mode: AM_ADD};

endpackage

// File: rtl/rvcd_classify.sv
module rvcd_classify
   import rvcd_pkg::*;
(
   input  logic [OPC_W-1:0] opcode_i,
   output iclass_e          class_o
);

   always_comb begin
      unique case (opcode_i)
         OPC_REG:    class_o = CL_REG;
         OPC_OPIMM:  class_o = CL_OPIMM;
         OPC_LOAD:   class_o = CL_LOAD;
         OPC_STORE:  class_o = CL_STORE;
         OPC_BRANCH: class_o = CL_BRANCH;
         OPC_JALR:   class_o = CL_JALR;
         OPC_JAL:    class_o = CL_JAL;
         OPC_LUI:    class_o = CL_LUI;
         OPC_AUIPC:  class_o = CL_AUIPC;
         default:    class_o = CL_NONE;
      endcase
   end

endmodule

// File: rtl/rvcd_alu_op.sv
module rvcd_alu_op
   import rvcd_pkg::*;
(
   input  alu_mode_e              mode_i,
   input  logic [F3_W-1:0]        funct3_i,
   input  logic                   alt_i,
   output logic [ALU_CODE_W-1:0]  alu_code_o
);

   logic imm_alt;

   // With an immediate operand only the right shifts carry a variant in bit 30;
   // elsewhere that bit belongs to the immediate value.
   assign imm_alt = (funct3_i == F3_SHIFT_RIGHT) & alt_i;

   always_comb begin
      unique case (mode_i)
         AM_REG:   alu_code_o = {alt_i, funct3_i};
         AM_IMM:   alu_code_o = {imm_alt, funct3_i};
         AM_PASSB: alu_code_o = ALU_CODE_PASSB;
         default:  alu_code_o = ALU_CODE_ADD;
      endcase
   end

endmodule

// File: rtl/rvcd_branch.sv
module rvcd_branch
   import rvcd_pkg::*;
(
   input  logic            is_branch_i,
   input  logic [F3_W-1:0] funct3_i,
   input  logic            eq_i,
   input  logic            lt_i,
   output logic            taken_o,
   output logic            unsigned_o
);

   logic cond;

   // funct3[2] picks the less-than family, funct3[0] inverts the test,
   // funct3[1] picks unsigned; 010 and 011 have no branch meaning.
   always_comb begin
      unique case (funct3_i)
         3'b000:  cond = eq_i;
         3'b001:  cond = ~eq_i;
         3'b100,
         3'b110:  cond = lt_i;
         3'b101,
         3'b111:  cond = ~lt_i;
         default: cond = 1'b0;
      endcase
   end

   assign taken_o    = is_branch_i & cond;
   assign unsigned_o = is_branch_i & funct3_i[1];

endmodule

// File: rtl/rv_ctrl_decode.sv
module rv_ctrl_decode
   import rvcd_pkg::*;
#(
   parameter int unsigned INST_W    = 32,
   parameter int unsigned IMM_SEL_W = 3,
   parameter int unsigned ALU_SEL_W = 4,
   parameter int unsigned WB_SEL_W  = 2
) (
   input  logic [INST_W-1:0]    inst_i,
   input  logic                 br_eq_i,
   input  logic                 br_lt_i,
   output logic                 pc_sel_o,
   output logic [IMM_SEL_W-1:0] imm_sel_o,
   output logic                 reg_wen_o,
   output logic                 br_unsigned_o,
   output logic                 a_sel_o,
   output logic                 b_sel_o,
   output logic [ALU_SEL_W-1:0] alu_sel_o,
   output logic                 mem_write_o,
   output logic [WB_SEL_W-1:0]  wb_sel_o
);

   localparam int unsigned F3_LSB  = OPC_W + 5;
   localparam int unsigned ALT_BIT = INST_W - 2;
   localparam int unsigned ALU_PAD = ALU_SEL_W - ALU_CODE_W;

   // Elaboration-time parameter checks
   generate
      if (INST_W != 32) begin : g_bad_inst_w
         $error("rv_ctrl_decode: INST_W must be 32");
      end
      if (IMM_SEL_W < IMM_CODE_W) begin : g_bad_imm_w
         $error("rv_ctrl_decode: IMM_SEL_W too narrow");
      end
      if (ALU_SEL_W < ALU_CODE_W) begin : g_bad_alu_w
         $error("rv_ctrl_decode: ALU_SEL_W too narrow");
      end
      if (WB_SEL_W < WB_CODE_W) begin : g_bad_wb_w
         $error("rv_ctrl_decode: WB_SEL_W too narrow");
      end
   endgenerate

   logic [OPC_W-1:0]      opcode;
   logic [F3_W-1:0]       funct3;
   logic                  alt_bit;
   iclass_e               iclass;
   ctrl_row_t             row;
   logic                  br_taken;
   logic                  br_unsigned;
   logic [ALU_CODE_W-1:0] alu_code;
   logic                  unused_inst_bits;

   assign opcode  = inst_i[OPC_W-1:0];
   assign funct3  = inst_i[F3_LSB +: F3_W];
   assign alt_bit = inst_i[ALT_BIT];
   assign unused_inst_bits = ^{inst_i[INST_W-1], inst_i[ALT_BIT-1:F3_LSB+F3_W],
                               inst_i[F3_LSB-1:OPC_W]};

   rvcd_classify u_classify (
      .opcode_i (opcode),
      .class_o  (iclass)
   );

   // Static control row per class
   always_comb begin
      row = ROW_QUIET;
      unique case (iclass)
         CL_REG: begin
            row.reg_wen  = 1'b1;
            row.wb       = WB_ALU;
            row.alu_mode = AM_REG;
         end
         CL_OPIMM: begin
            row.imm      = IMM_I;
            row.reg_wen  = 1'b1;
            row.b_imm    = 1'b1;
            row.wb       = WB_ALU;
            row.alu_mode = AM_IMM;
         end
         CL_LOAD: begin
            row.imm      = IMM_I;
            row.reg_wen  = 1'b1;
            row.b_imm    = 1'b1;
            row.wb       = WB_MEM;
         end
         CL_STORE: begin
            row.imm      = IMM_S;
            row.b_imm    = 1'b1;
            row.mem_wr   = 1'b1;
         end
         CL_BRANCH: begin
            row.imm      = IMM_B;
            row.a_pc     = 1'b1;
            row.b_imm    = 1'b1;
         end
         CL_JALR: begin
            row.jump     = 1'b1;
            row.imm      = IMM_I;
            row.reg_wen  = 1'b1;
            row.b_imm    = 1'b1;
            row.wb       = WB_LINK;
         end
         CL_JAL: begin
            row.jump     = 1'b1;
            row.imm      = IMM_J;
            row.reg_wen  = 1'b1;
            row.a_pc     = 1'b1;
            row.b_imm    = 1'b1;
            row.wb       = WB_LINK;
         end
         CL_LUI: begin
            row.imm      = IMM_U;
            row.reg_wen  = 1'b1;
            row.b_imm    = 1'b1;
            row.wb       = WB_ALU;
            row.alu_mode = AM_PASSB;
         end
         CL_AUIPC: begin
            row.imm      = IMM_U;
            row.reg_wen  = 1'b1;
            row.a_pc     = 1'b1;
            row.b_imm    = 1'b1;
            row.wb       = WB_ALU;
         end
         default: row = ROW_QUIET;
      endcase
   end

   rvcd_alu_op u_alu_op (
      .mode_i     (row.alu_mode),
      .funct3_i   (funct3),
      .alt_i      (alt_bit),
      .alu_code_o (alu_code)
   );

   rvcd_branch u_branch (
      .is_branch_i (iclass == CL_BRANCH),
      .funct3_i    (funct3),
      .eq_i        (br_eq_i),
      .lt_i        (br_lt_i),
      .taken_o     (br_taken),
      .unsigned_o  (br_unsigned)
   );

   assign pc_sel_o      = row.jump | br_taken;
   assign imm_sel_o     = IMM_SEL_W'(row.imm);
   assign reg_wen_o     = row.reg_wen;
   assign br_unsigned_o = br_unsigned;
   assign a_sel_o       = row.a_pc;
   assign b_sel_o       = row.b_imm;
   assign mem_write_o   = row.mem_wr;
   assign wb_sel_o      = WB_SEL_W'(row.wb);

   // Wider ALU select buses carry the native code zero-extended
   generate
      if (ALU_PAD == 0) begin : g_alu_native
         assign alu_sel_o = alu_code;
      end else begin : g_alu_padded
         assign alu_sel_o = {{ALU_PAD{1'b0}}, alu_code};
      end
   endgenerate

endmodule

// File: rtl/rv_ctrl_decode_chk.sv
module rv_ctrl_decode_chk
   import rvcd_pkg::*;
#(
   parameter int unsigned INST_W    = 32,
   parameter int unsigned IMM_SEL_W = 3,
   parameter int unsigned ALU_SEL_W = 4,
   parameter int unsigned WB_SEL_W  = 2
) (
   input logic [INST_W-1:0]    inst_i,
   input logic                 br_eq_i,
   input logic                 br_lt_i,
   input logic                 pc_sel_o,
   input logic [IMM_SEL_W-1:0] imm_sel_o,
   input logic                 reg_wen_o,
   input logic                 br_unsigned_o,
   input logic                 a_sel_o,
   input logic                 b_sel_o,
   input logic [ALU_SEL_W-1:0] alu_sel_o,
   input logic                 mem_write_o,
   input logic [WB_SEL_W-1:0]  wb_sel_o
);

   logic [6:0] opc;
   logic       known;
   logic       known_inputs;
   logic       unused_chk;

   assign opc   = inst_i[6:0];
   assign known = (opc == OPC_REG) || (opc == OPC_OPIMM) || (opc == OPC_LOAD) ||
                  (opc == OPC_STORE) || (opc == OPC_BRANCH) || (opc == OPC_JALR) ||
                  (opc == OPC_JAL) || (opc == OPC_LUI) || (opc == OPC_AUIPC);
   assign known_inputs = !$isunknown({inst_i, br_eq_i, br_lt_i});
   assign unused_chk   = ^{alu_sel_o, inst_i[INST_W-1:14], inst_i[12:7]};

   always_comb begin
      if (known_inputs) begin
         assert_store_no_regwrite_R4: assert (!(mem_write_o && reg_wen_o))
            else $error("memory write together with register write");
         assert_unknown_quiet_R11: assert (known || (!reg_wen_o && !mem_write_o && !pc_sel_o))
            else $error("unknown opcode produced a side effect");
         assert_pc_redirect_source_R6: assert (!pc_sel_o ||
               opc == OPC_BRANCH || opc == OPC_JAL || opc == OPC_JALR)
            else $error("PC redirected by a non-control-flow opcode");
         assert_reg_operands_R1: assert (opc != OPC_REG || (!a_sel_o && !b_sel_o))
            else $error("register operation not using rs1/rs2");
         assert_branch_signedness_R5: assert (opc != OPC_BRANCH || br_unsigned_o == inst_i[13])
            else $error("comparator signedness mismatch");
         assert_codes_legal_R13: assert (wb_sel_o <= WB_SEL_W'(2) && imm_sel_o <= IMM_SEL_W'(4))
            else $error("illegal select code");
      end
   end

endmodule

bind rv_ctrl_decode rv_ctrl_decode_chk #(
   .INST_W    (INST_W),
   .IMM_SEL_W (IMM_SEL_W),
   .ALU_SEL_W (ALU_SEL_W),
   .WB_SEL_W  (WB_SEL_W)
) u_chk (
   .inst_i        (inst_i),
   .br_eq_i       (br_eq_i),
   .br_lt_i       (br_lt_i),
   .pc_sel_o      (pc_sel_o),
   .imm_sel_o     (imm_sel_o),
   .reg_wen_o     (reg_wen_o),
   .br_unsigned_o (br_unsigned_o),
   .a_sel_o       (a_sel_o),
   .b_sel_o       (b_sel_o),
   .alu_sel_o     (alu_sel_o),
   .mem_write_o   (mem_write_o),
   .wb_sel_o      (wb_sel_o)
);

// File: tb/rv_ctrl_decode_bench.sv
`timescale 1ns/1ps
module rv_ctrl_decode_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] inst;
   logic        br_eq, br_lt;
   logic        pc_sel, reg_wen, br_un, a_sel, b_sel, mem_write;
   logic [2:0]  imm_sel;
   logic [3:0]  alu_sel;
   logic [1:0]  wb_sel;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   rv_ctrl_decode u_rv_ctrl_decode (
      .inst_i        (inst),
      .br_eq_i       (br_eq),
      .br_lt_i       (br_lt),
      .pc_sel_o      (pc_sel),
      .imm_sel_o     (imm_sel),
      .reg_wen_o     (reg_wen),
      .br_unsigned_o (br_un),
      .a_sel_o       (a_sel),
      .b_sel_o       (b_sel),
      .alu_sel_o     (alu_sel),
      .mem_write_o   (mem_write),
      .wb_sel_o      (wb_sel)
   );

   // Packed view: pc | imm[2:0] | wen | un | a | b | alu[3:0] | mem | wb[1:0]
   localparam logic [14:0] M_R = 15'b1_000_1_0_1_1_1111_1_11;
   localparam logic [14:0] M_I = 15'b1_111_1_0_1_1_1111_1_11;
   localparam logic [14:0] M_S = 15'b1_111_1_0_1_1_1111_1_00;
   localparam logic [14:0] M_B = 15'b1_111_1_1_1_1_1111_1_00;
   localparam logic [14:0] M_U = 15'b1_111_1_0_0_1_1111_1_11;
   localparam logic [14:0] M_N = 15'b1_000_1_0_0_0_0000_1_00;

   localparam logic [31:0] I_ADD   = {7'h00, 5'd2, 5'd1, 3'd0, 5'd3, 7'h33};
   localparam logic [31:0] I_SUB   = {7'h20, 5'd2, 5'd1, 3'd0, 5'd3, 7'h33};
   localparam logic [31:0] I_SRA   = {7'h20, 5'd2, 5'd1, 3'd5, 5'd3, 7'h33};
   localparam logic [31:0] I_SLTU  = {7'h00, 5'd2, 5'd1, 3'd3, 5'd3, 7'h33};
   localparam logic [31:0] I_ADDI  = {12'h400, 5'd1, 3'd0, 5'd3, 7'h13};
   localparam logic [31:0] I_SRAI  = {7'h20, 5'd4, 5'd1, 3'd5, 5'd3, 7'h13};
   localparam logic [31:0] I_SRLI  = {7'h00, 5'd4, 5'd1, 3'd5, 5'd3, 7'h13};
   localparam logic [31:0] I_ANDI  = {12'hFFF, 5'd1, 3'd7, 5'd3, 7'h13};
   localparam logic [31:0] I_LW    = {12'h010, 5'd1, 3'd2, 5'd3, 7'h03};
   localparam logic [31:0] I_SW    = {7'h00, 5'd2, 5'd1, 3'd2, 5'd4, 7'h23};
   localparam logic [31:0] I_BEQ   = {7'h00, 5'd2, 5'd1, 3'd0, 5'd8, 7'h63};
   localparam logic [31:0] I_BNE   = {7'h00, 5'd2, 5'd1, 3'd1, 5'd8, 7'h63};
   localparam logic [31:0] I_BLT   = {7'h00, 5'd2, 5'd1, 3'd4, 5'd8, 7'h63};
   localparam logic [31:0] I_BGE   = {7'h00, 5'd2, 5'd1, 3'd5, 5'd8, 7'h63};
   localparam logic [31:0] I_BLTU  = {7'h00, 5'd2, 5'd1, 3'd6, 5'd8, 7'h63};
   localparam logic [31:0] I_BGEU  = {7'h00, 5'd2, 5'd1, 3'd7, 5'd8, 7'h63};
   localparam logic [31:0] I_JALR  = {12'h004, 5'd1, 3'd0, 5'd1, 7'h67};
   localparam logic [31:0] I_JAL   = {20'h00100, 5'd1, 7'h6F};
   localparam logic [31:0] I_LUI   = {20'hABCDE, 5'd5, 7'h37};
   localparam logic [31:0] I_AUIPC = {20'hABCDE, 5'd5, 7'h17};
   localparam logic [31:0] I_FENCE = {25'h0, 7'h0F};

   // {req[3:0], inst[31:0], eq, lt, expected[14:0], mask[14:0]}
   localparam int NV = 24;
   localparam logic [67:0] VEC [0:NV-1] = '{
      {4'd1,  I_ADD,   1'b0, 1'b0, 15'b0_000_1_0_0_0_0000_0_01, M_R},
      {4'd1,  I_SUB,   1'b0, 1'b0, 15'b0_000_1_0_0_0_1000_0_01, M_R},
      {4'd1,  I_SRA,   1'b0, 1'b0, 15'b0_000_1_0_0_0_1101_0_01, M_R},
      {4'd1,  I_SLTU,  1'b0, 1'b0, 15'b0_000_1_0_0_0_0011_0_01, M_R},
      {4'd2,  I_ADDI,  1'b0, 1'b0, 15'b0_000_1_0_0_1_0000_0_01, M_I},
      {4'd2,  I_SRAI,  1'b0, 1'b0, 15'b0_000_1_0_0_1_1101_0_01, M_I},
      {4'd2,  I_SRLI,  1'b0, 1'b0, 15'b0_000_1_0_0_1_0101_0_01, M_I},
      {4'd2,  I_ANDI,  1'b0, 1'b0, 15'b0_000_1_0_0_1_0111_0_01, M_I},
      {4'd3,  I_LW,    1'b0, 1'b0, 15'b0_000_1_0_0_1_0000_0_00, M_I},
      {4'd4,  I_SW,    1'b0, 1'b0, 15'b0_001_0_0_0_1_0000_1_00, M_S},
      {4'd6,  I_BEQ,   1'b1, 1'b0, 15'b1_010_0_0_1_1_0000_0_00, M_B},
      {4'd6,  I_BEQ,   1'b0, 1'b1, 15'b0_010_0_0_1_1_0000_0_00, M_B},
      {4'd6,  I_BNE,   1'b1, 1'b0, 15'b0_010_0_0_1_1_0000_0_00, M_B},
      {4'd6,  I_BLT,   1'b0, 1'b1, 15'b1_010_0_0_1_1_0000_0_00, M_B},
      {4'd6,  I_BGE,   1'b0, 1'b1, 15'b0_010_0_0_1_1_0000_0_00, M_B},
      {4'd5,  I_BLTU,  1'b0, 1'b1, 15'b1_010_0_1_1_1_0000_0_00, M_B},
      {4'd5,  I_BGEU,  1'b1, 1'b0, 15'b1_010_0_1_1_1_0000_0_00, M_B},
      {4'd7,  I_JALR,  1'b0, 1'b0, 15'b1_000_1_0_0_1_0000_0_10, M_I},
      {4'd8,  I_JAL,   1'b0, 1'b0, 15'b1_011_1_0_1_1_0000_0_10, M_I},
      {4'd9,  I_LUI,   1'b0, 1'b0, 15'b0_100_1_0_0_1_1111_0_01, M_U},
      {4'd10, I_AUIPC, 1'b0, 1'b0, 15'b0_100_1_0_1_1_0000_0_01, M_I},
      {4'd11, I_FENCE, 1'b1, 1'b1, 15'b0_000_0_0_0_0_0000_0_00, M_N},
      {4'd11, 32'h0,   1'b1, 1'b1, 15'b0_000_0_0_0_0_0000_0_00, M_N},
      {4'd12, I_ADD,   1'b1, 1'b1, 15'b0_000_1_0_0_0_0000_0_01, M_R}
   };

   function automatic string req_tag(int n);
      case (n)
         1: return "R1";   2: return "R2";   3: return "R3";
         4: return "R4";   5: return "R5";   6: return "R6";
         7: return "R7";   8: return "R8";   9: return "R9";
         10: return "R10"; 11: return "R11"; 12: return "R12";
         default: return "R13";
      endcase
   endfunction

   // Taken model from the requirement text (R6)
   function automatic logic model_taken(logic [2:0] f3, logic eq, logic lt);
      case (f3)
         3'b000: return eq;
         3'b001: return !eq;
         3'b100, 3'b110: return lt;
         3'b101, 3'b111: return !lt;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic is_known_opc(logic [6:0] op);
      return op == 7'h33 || op == 7'h13 || op == 7'h03 || op == 7'h23 || op == 7'h63 ||
             op == 7'h67 || op == 7'h6F || op == 7'h37 || op == 7'h17;
   endfunction

   function automatic logic [14:0] act_word();
      return {pc_sel, imm_sel, reg_wen, br_un, a_sel, b_sel, alu_sel, mem_write, wb_sel};
   endfunction

   task automatic apply(input logic [31:0] i, input logic eq, input logic lt);
      @(negedge clk);
      inst  = i;
      br_eq = eq;
      br_lt = lt;
      #1;
   endtask

   task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp,
                        input logic [14:0] mask, input logic [31:0] i);
      checks++;
      if ((act & mask) !== (exp & mask)) begin
         errors++;
         $display("FAIL %s inst=%h actual=%b expected=%b mask=%b", tag, i, act, exp, mask);
      end
   endtask

   initial begin
      inst  = 32'h0;
      br_eq = 1'b1;
      br_lt = 1'b1;
      // Reset state: zero word held during reset must be inert (R11)
      #1;
      check("R11", act_word(), 15'h0, M_N, inst);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // Vector table
      for (int k = 0; k < NV; k++) begin
         apply(VEC[k][63:32], VEC[k][31], VEC[k][30]);
         check(req_tag(int'(VEC[k][67:64])), act_word(), VEC[k][29:15], VEC[k][14:0],
               VEC[k][63:32]);
      end

      // Opcode sweep with both flags high: unknown opcodes inert (R11), codes legal (R13)
      for (int op = 0; op < 128; op++) begin
         apply({7'h7F, 5'd31, 5'd31, 3'd7, 5'd31, 7'(op)}, 1'b1, 1'b1);
         if (!is_known_opc(7'(op)))
            check("R11", act_word(), 15'h0, M_N, inst);
         checks++;
         if (wb_sel > 2'd2 || imm_sel > 3'd4) begin
            errors++;
            $display("FAIL R13 inst=%h actual wb=%0d imm=%0d expected wb<=2 imm<=4",
                     inst, wb_sel, imm_sel);
         end
      end

      // Branch sweep: every funct3 against every flag pair (R6, R5)
      for (int f = 0; f < 8; f++) begin
         for (int fl = 0; fl < 4; fl++) begin
            logic e, l;
            e = fl[1];
            l = fl[0];
            apply({7'h00, 5'd2, 5'd1, 3'(f), 5'd8, 7'h63}, e, l);
            check("R6", {14'h0, pc_sel}, {14'h0, model_taken(3'(f), e, l)}, 15'h0001, inst);
            if (f != 2 && f != 3)
               check("R5", {14'h0, br_un}, {14'h0, 1'(f >> 1)}, 15'h0001, inst);
         end
      end

      // Flags must not move any output of a non-branch opcode (R12)
      for (int k = 0; k < NV; k++) begin
         logic [31:0] i;
         logic [14:0] base;
         i = VEC[k][63:32];
         if (i[6:0] != 7'h63) begin
            apply(i, 1'b0, 1'b0);
            base = act_word();
            for (int fl = 1; fl < 4; fl++) begin
               apply(i, fl[1], fl[0]);
               check("R12", act_word(), base, 15'h7FFF, i);
            end
         end
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule